// File: doc/BRIEF.md
# Lane-Banked SIMD Operand Register File

This block holds the operands of a four-lane SIMD datapath. Its 128 nominal 64-bit registers are stored as 256 separate 32-bit entries, spread over four lane banks. Each bank keeps an upper and a lower 32-bit half for every row. A 64-bit operand is the two halves of one row placed side by side. A 32-bit access reaches a single half, so a renaming or remapping stage can address storage at 32-bit granularity.

A 7-bit register number is split in two parts. The upper five bits pick a row, and that row is read in all four banks at once. The lower two bits add a lane offset to the crossbar steering. There are two read ports. Each one sends the four bank outputs through its own full four-by-four crossbar, so every ALU input lane can take data from any bank. Each read port also has a lane mask that blanks the lanes it does not use. The single write port sets one row in all banks, and a predicate mask decides which lanes actually take the write. A width flag chooses between a full 64-bit write and a write to one half.

Top module: `lrf_regfile`

## Requirements
- R1: Reads are synchronous. The value on `rd_data` in the cycle after a rising clock edge reflects the request sampled at that edge and the storage contents before that edge.
- R2: A read uses row `rd_reg[6:2]` in every bank. Output lane j takes its data from bank `(rd_sel[j] + rd_reg[1:0]) mod 4`.
- R3: A wide read (`rd_wide`=1) returns, on each lane, the upper half of the row in bits 63:32 and the lower half in bits 31:0.
- R4: A narrow read (`rd_wide`=0) returns one half, zero-extended into bits 31:0. `rd_half`=1 selects the upper half and 0 selects the lower half. Bits 63:32 read as zero.
- R5: A wide write stores `wr_data[j][63:32]` into the upper half and `wr_data[j][31:0]` into the lower half of row `wr_row` in bank j.
- R6: A narrow write stores `wr_data[j][31:0]` only into the half named by `wr_half` (1 = upper). The other half of that row keeps its contents.
- R7: A bank whose `wr_mask` bit is 0 keeps its contents. When `wr_en` is 0, no bank is written.
- R8: A read of the same row that is being written in the same cycle returns the contents from before the write. The new data shows up from the following read onward.
- R9: An output lane whose `rd_mask` bit was 0 at the sampling edge drives all zeros.
- R10: While `rst_n` is low, writes are blocked and both read ports return zero on every lane. Reset also returns the crossbar steering to identity. Storage is not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_row | input | 5 | Row written in all banks |
| wr_wide | input | 1 | 1 = 64-bit write, 0 = 32-bit write |
| wr_half | input | 1 | Half written by a 32-bit write (1 = upper) |
| wr_mask | input | 4 | Per-lane write predicate |
| wr_data | input | 4x64 | Write data per lane |
| rd_reg | input | 2x7 | Register number per read port |
| rd_wide | input | 2 | 1 = 64-bit read, per port |
| rd_half | input | 2 | Half read by a 32-bit read (1 = upper), per port |
| rd_mask | input | 2x4 | Output lane enables per port |
| rd_sel | input | 2x4x2 | Source-lane select per output lane per port |
| rd_data | output | 2x4x64 | Crossbar outputs per port and lane |

## Verification
The assertions assume that the reset is held low for at least one rising edge before any check relies on reset values. They also assume that a read following a wide write reads a row that was written earlier. Storage has no reset, so the bench writes every row before it checks any data-carrying read. The random phase only reads rows that this initial fill has already defined, and it mixes widths, halves, masks, offsets and selects freely within the encodings listed above.

// File: rtl/lrf_pkg.sv
package lrf_pkg;
   localparam int LRF_LANES    = 4;
   localparam int LRF_REG_BITS = 7;
   localparam int LRF_HALF_W   = 32;
   localparam int LRF_NRD      = 2;

   // access width of one element
   typedef enum logic {
      ELEM_HALF = 1'b0,
      ELEM_FULL = 1'b1
   } elem_w_e;
endpackage

// File: rtl/lrf_bank.sv
module lrf_bank #(
   parameter int ROWS   = 32,
   parameter int HALF_W = 32,
   parameter int NRD    = 2,
   localparam int ROW_BITS = $clog2(ROWS),
   localparam int WORD_W   = 2 * HALF_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [ROW_BITS-1:0]            wr_row,
   input  logic                           wr_wide,
   input  logic                           wr_half,
   input  logic [WORD_W-1:0]              wr_data,
   input  logic [NRD-1:0][ROW_BITS-1:0]   rd_row,
   input  logic [NRD-1:0]                 rd_wide,
   input  logic [NRD-1:0]                 rd_half,
   output logic [NRD-1:0][WORD_W-1:0]     rd_q
);
   import lrf_pkg::*;

   if (ROWS != (1 << ROW_BITS)) begin : g_bad_rows
      $error("lrf_bank: ROWS must be a power of two");
   end
   if (NRD < 1) begin : g_bad_nrd
      $error("lrf_bank: at least one read port required");
   end

   logic [HALF_W-1:0] mem_hi [ROWS];
   logic [HALF_W-1:0] mem_lo [ROWS];

   always_ff @(posedge clk) begin
      if (we) begin
         if (elem_w_e'(wr_wide) == ELEM_FULL) begin
            mem_hi[wr_row] <= wr_data[WORD_W-1:HALF_W];
            mem_lo[wr_row] <= wr_data[HALF_W-1:0];
         end else if (wr_half) begin
            mem_hi[wr_row] <= wr_data[HALF_W-1:0];
         end else begin
            mem_lo[wr_row] <= wr_data[HALF_W-1:0];
         end
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk) begin
         if (elem_w_e'(rd_wide[p]) == ELEM_FULL)
            q <= {mem_hi[rd_row[p]], mem_lo[rd_row[p]]};
         else
            q <= {{HALF_W{1'b0}}, (rd_half[p] ? mem_hi[rd_row[p]] : mem_lo[rd_row[p]])};
      end
      assign rd_q[p] = q;

      // R4: a narrow read leaves the upper half of the result at zero
      p_narrow_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_wide[p] |=> (rd_q[p][WORD_W-1:HALF_W] == '0));
   end

   // R5 / R8: wide write followed by a wide read of that row returns the written word
   p_wr_then_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wr_wide) ##1 (rd_wide[0] && (rd_row[0] == $past(wr_row)))
      |=> (rd_q[0] == $past(wr_data, 2)));
endmodule

// File: rtl/lrf_xbar.sv
module lrf_xbar #(
   parameter int LANES = 4,
   parameter int W     = 64,
   localparam int SB   = $clog2(LANES)
) (
   input  logic [LANES-1:0][W-1:0]  in_lane,
   input  logic [LANES-1:0][SB-1:0] sel,
   input  logic [LANES-1:0]         en,
   output logic [LANES-1:0][W-1:0]  out_lane
);
   if (LANES != (1 << SB) || LANES < 2) begin : g_bad_lanes
      $error("lrf_xbar: LANES must be a power of two of at least 2");
   end

   for (genvar j = 0; j < LANES; j++) begin : g_out
      assign out_lane[j] = en[j] ? in_lane[sel[j]] : '0;
   end
endmodule

// File: rtl/lrf_regfile.sv
module lrf_regfile
   import lrf_pkg::*;
#(
   parameter int LANES    = LRF_LANES,
   parameter int REG_BITS = LRF_REG_BITS,
   parameter int HALF_W   = LRF_HALF_W,
   parameter int NRD      = LRF_NRD,
   localparam int LANE_BITS = $clog2(LANES),
   localparam int ROW_BITS  = REG_BITS - LANE_BITS,
   localparam int ROWS      = 1 << ROW_BITS,
   localparam int WORD_W    = 2 * HALF_W
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   wr_en,
   input  logic [ROW_BITS-1:0]                    wr_row,
   input  logic                                   wr_wide,
   input  logic                                   wr_half,
   input  logic [LANES-1:0]                       wr_mask,
   input  logic [LANES-1:0][WORD_W-1:0]           wr_data,
   input  logic [NRD-1:0][REG_BITS-1:0]           rd_reg,
   input  logic [NRD-1:0]                         rd_wide,
   input  logic [NRD-1:0]                         rd_half,
   input  logic [NRD-1:0][LANES-1:0]              rd_mask,
   input  logic [NRD-1:0][LANES-1:0][LANE_BITS-1:0] rd_sel,
   output logic [NRD-1:0][LANES-1:0][WORD_W-1:0]  rd_data
);
   if (ROW_BITS < 1) begin : g_bad_reg_bits
      $error("lrf_regfile: REG_BITS must exceed the lane index width");
   end
   if (LANES != (1 << LANE_BITS)) begin : g_bad_lanes
      $error("lrf_regfile: LANES must be a power of two");
   end

   logic                                  wr_go;
   logic [LANES-1:0]                      bank_we;
   logic [NRD-1:0][ROW_BITS-1:0]          rd_row;
   logic [LANES-1:0][NRD-1:0][WORD_W-1:0] bank_q;
   logic [NRD-1:0][LANES-1:0][WORD_W-1:0] xin;
   logic [NRD-1:0][LANES-1:0][LANE_BITS-1:0] sel_q;
   logic [NRD-1:0][LANES-1:0]             en_q;

   assign wr_go = wr_en & rst_n;

   for (genvar p = 0; p < NRD; p++) begin : g_port
      assign rd_row[p] = rd_reg[p][REG_BITS-1:LANE_BITS];

      // steering state: row offset folded into the per-lane selects
      for (genvar j = 0; j < LANES; j++) begin : g_sel
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sel_q[p][j] <= LANE_BITS'(j);
               en_q[p][j]  <= 1'b0;
            end else begin
               sel_q[p][j] <= rd_sel[p][j] + rd_reg[p][LANE_BITS-1:0];
               en_q[p][j]  <= rd_mask[p][j];
            end
         end
         assign xin[p][j] = bank_q[j][p];

         // R10: reset returns the steering to identity
         p_reset_ident_r10: assert property (@(posedge clk)
            !rst_n |=> (sel_q[p][j] == LANE_BITS'(j)));
         // R9: a lane masked off at the request drives zero
         p_lane_off_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_mask[p][j] |=> (rd_data[p][j] == '0));
      end

      lrf_xbar #(.LANES(LANES), .W(WORD_W)) u_xbar (
         .in_lane  (xin[p]),
         .sel      (sel_q[p]),
         .en       (en_q[p]),
         .out_lane (rd_data[p])
      );

      // R10: outputs are blank after a reset cycle
      p_reset_blank_r10: assert property (@(posedge clk)
         !rst_n |=> (rd_data[p] == '0));
   end

   for (genvar j = 0; j < LANES; j++) begin : g_bank
      assign bank_we[j] = wr_go & wr_mask[j];

      lrf_bank #(.ROWS(ROWS), .HALF_W(HALF_W), .NRD(NRD)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .we      (bank_we[j]),
         .wr_row  (wr_row),
         .wr_wide (wr_wide),
         .wr_half (wr_half),
         .wr_data (wr_data[j]),
         .rd_row  (rd_row),
         .rd_wide (rd_wide),
         .rd_half (rd_half),
         .rd_q    (bank_q[j])
      );
   end

   // R7: the number of banks written never exceeds the predicate population
   p_pred_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(bank_we) <= $countones(wr_mask));
endmodule

// File: tb/lrf_regfile_bench.sv
module lrf_regfile_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [4:0] wr_row = '0;
   logic wr_wide = 1'b0, wr_half = 1'b0;
   logic [3:0] wr_mask = '0;
   logic [3:0][63:0] wr_data = '0;
   logic [1:0][6:0] rd_reg = '0;
   logic [1:0] rd_wide = '0, rd_half = '0;
   logic [1:0][3:0] rd_mask = '0;
   logic [1:0][3:0][1:0] rd_sel = '0;
   logic [1:0][3:0][63:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] m_hi [4][32];
   logic [31:0] m_lo [4][32];

   localparam logic [7:0] IDENT = 8'b11_10_01_00;

   always #5 clk = ~clk;

   lrf_regfile u_lrf_regfile (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
      .wr_wide(wr_wide), .wr_half(wr_half), .wr_mask(wr_mask), .wr_data(wr_data),
      .rd_reg(rd_reg), .rd_wide(rd_wide), .rd_half(rd_half), .rd_mask(rd_mask),
      .rd_sel(rd_sel), .rd_data(rd_data)
   );

   function automatic logic [63:0] exp_lane(int p, int j);
      int src;
      int row;
      src = (int'(rd_sel[p][j]) + int'(rd_reg[p][1:0])) % 4;
      row = int'(rd_reg[p][6:2]);
      if (!rd_mask[p][j]) return '0;
      if (rd_wide[p]) return {m_hi[src][row], m_lo[src][row]};
      if (rd_half[p]) return {32'h0, m_hi[src][row]};
      return {32'h0, m_lo[src][row]};
   endfunction

   task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   // inputs are set at a falling edge; one rising edge later the result is sampled
   task automatic step(string tag);
      logic [1:0][3:0][63:0] e;
      for (int p = 0; p < 2; p++)
         for (int j = 0; j < 4; j++)
            e[p][j] = rst_n ? exp_lane(p, j) : 64'h0;
      if (wr_en && rst_n) begin
         for (int j = 0; j < 4; j++) begin
            if (wr_mask[j]) begin
               if (wr_wide) begin
                  m_hi[j][wr_row] = wr_data[j][63:32];
                  m_lo[j][wr_row] = wr_data[j][31:0];
               end else if (wr_half) m_hi[j][wr_row] = wr_data[j][31:0];
               else m_lo[j][wr_row] = wr_data[j][31:0];
            end
         end
      end
      @(negedge clk);
      for (int p = 0; p < 2; p++) begin
         checks++;
         if (rd_data[p] !== e[p]) begin
            errors++;
            $display("FAIL %s port %0d got %h expected %h", tag, p, rd_data[p], e[p]);
         end
      end
   endtask

   task automatic set_rd(int p, logic [6:0] r, logic w, logic h, logic [3:0] m, logic [7:0] s);
      rd_reg[p] = r; rd_wide[p] = w; rd_half[p] = h; rd_mask[p] = m; rd_sel[p] = s;
   endtask

   function automatic logic [63:0] pat(int j, int row);
      return {8'(j), 8'(row), 16'hC0DE, 8'(j), 8'(row), 16'h5A5A};
   endfunction

   initial begin
      int seed;
      seed = $urandom(32'h1DE5);
      @(negedge clk);
      // R10: outputs blank in reset
      set_rd(0, 7'd0, 1'b1, 1'b0, 4'hF, IDENT);
      set_rd(1, 7'd4, 1'b1, 1'b0, 4'hF, IDENT);
      step("R10");
      step("R10");
      rst_n = 1'b1;
      // fill every row; port 0 reads the row under write (R8: old data is unknown, so masked)
      for (int row = 0; row < 32; row++) begin
         wr_en = 1'b1; wr_wide = 1'b1; wr_mask = 4'hF; wr_row = 5'(row);
         for (int j = 0; j < 4; j++) wr_data[j] = pat(j, row);
         set_rd(0, {5'(row), 2'b00}, 1'b1, 1'b0, 4'h0, IDENT);
         set_rd(1, {5'(row), 2'b00}, 1'b1, 1'b0, 4'h0, IDENT);
         step("R5");
      end
      wr_en = 1'b0;
      // R3 / R5: identity wide read
      set_rd(0, {5'd5, 2'b00}, 1'b1, 1'b0, 4'hF, IDENT);
      set_rd(1, {5'd31, 2'b00}, 1'b1, 1'b0, 4'hF, IDENT);
      step("R3");
      chk("R5 lane2 row5", rd_data[0][2], pat(2, 5));
      // R2: row offset rotates, broadcast select
      set_rd(0, {5'd5, 2'b10}, 1'b1, 1'b0, 4'hF, IDENT);
      set_rd(1, {5'd6, 2'b01}, 1'b1, 1'b0, 4'hF, 8'hFF);
      step("R2");
      chk("R2 rotate lane0", rd_data[0][0], pat(2, 5));
      chk("R2 broadcast lane1", rd_data[1][1], pat(0, 6));
      // R4: narrow reads of each half
      set_rd(0, {5'd3, 2'b00}, 1'b0, 1'b1, 4'hF, IDENT);
      set_rd(1, {5'd3, 2'b00}, 1'b0, 1'b0, 4'hF, IDENT);
      step("R4");
      chk("R4 upper half", rd_data[0][0], {32'h0, 8'd0, 8'd3, 16'hC0DE});
      chk("R4 lower half", rd_data[1][3], {32'h0, 8'd3, 8'd3, 16'h5A5A});
      // R6: narrow write to upper half of row 7
      wr_en = 1'b1; wr_wide = 1'b0; wr_half = 1'b1; wr_mask = 4'hF; wr_row = 5'd7;
      for (int j = 0; j < 4; j++) wr_data[j] = {32'hFFFF_FFFF, 32'hDEAD_0000 | 32'(j)};
      step("R6");
      wr_en = 1'b0;
      set_rd(0, {5'd7, 2'b00}, 1'b1, 1'b0, 4'hF, IDENT);
      step("R6");
      chk("R6 other half kept", rd_data[0][1], {32'hDEAD_0001, pat(1, 7)[31:0]});
      // R7: predicated write, then disabled write
      wr_en = 1'b1; wr_wide = 1'b1; wr_mask = 4'b0101; wr_row = 5'd9;
      for (int j = 0; j < 4; j++) wr_data[j] = 64'h1234_5678_9ABC_DEF0 + 64'(j);
      step("R7");
      wr_mask = 4'hF; wr_en = 1'b0;
      set_rd(0, {5'd9, 2'b00}, 1'b1, 1'b0, 4'hF, IDENT);
      step("R7");
      chk("R7 masked lane kept", rd_data[0][1], pat(1, 9));
      step("R7");
      // R8: same-cycle read and write of row 11
      wr_en = 1'b1; wr_wide = 1'b1; wr_mask = 4'hF; wr_row = 5'd11;
      for (int j = 0; j < 4; j++) wr_data[j] = 64'hAAAA_0000_BBBB_0000 + 64'(j);
      set_rd(0, {5'd11, 2'b00}, 1'b1, 1'b0, 4'hF, IDENT);
      step("R8");
      chk("R8 old data", rd_data[0][0], pat(0, 11));
      wr_en = 1'b0;
      step("R8");
      chk("R8 new data next", rd_data[0][0], 64'hAAAA_0000_BBBB_0000);
      // R9: read-side lane mask
      set_rd(1, {5'd12, 2'b00}, 1'b1, 1'b0, 4'b1010, IDENT);
      step("R9");
      chk("R9 lane off", rd_data[1][0], 64'h0);
      // R10: writes blocked during reset, storage kept
      rst_n = 1'b0; wr_en = 1'b1; wr_wide = 1'b1; wr_mask = 4'hF; wr_row = 5'd0;
      for (int j = 0; j < 4; j++) wr_data[j] = '1;
      step("R10");
      rst_n = 1'b1; wr_en = 1'b0;
      set_rd(0, {5'd0, 2'b00}, 1'b1, 1'b0, 4'hF, IDENT);
      step("R10");
      chk("R10 storage kept", rd_data[0][3], pat(3, 0));
      // R1: constrained random traffic against the model
      for (int n = 0; n < 400; n++) begin
         wr_en = ($urandom % 3) == 0;
         wr_wide = 1'($urandom); wr_half = 1'($urandom);
         wr_mask = 4'($urandom); wr_row = 5'($urandom);
         for (int j = 0; j < 4; j++) wr_data[j] = {$urandom, $urandom};
         for (int p = 0; p < 2; p++)
            set_rd(p, 7'($urandom), 1'($urandom), 1'($urandom), 4'($urandom), 8'($urandom));
         step("R1");
      end
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog R1 got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule